// File: doc/BRIEF.md
# Sector Write-Protection Checker

This block rules on every program or erase request aimed at a 22-bit word address of a large flash array. It finds the sector that holds the address and reports one clock later whether the operation may go ahead. The sector layout is not uniform. The lowest and the highest 32 Kword region are each split into eight small 4 Kword boot sectors. The 126 regions between them are single 32 Kword sectors, which gives 142 sectors in all.

Protection comes in layers. Each sector has its own lock bit, which software sets and clears through commands. An active-low write-protect pin guards the four lowest and the four highest boot sectors whatever their lock bits hold. An acceleration-level pin held low locks the whole array. A 64-bit password gate decides whether lock-bit commands take effect. The gate opens only when the matching key is presented, and loading a new key closes it again.

Top module: `wp_sector_guard`

## Requirements
- R1: The address map holds 4 Kword sectors 0..7 at word addresses 0x000000..0x007FFF, 32 Kword sectors 8..133 over the next 126 regions, and 4 Kword sectors 134..141 at 0x3F8000..0x3FFFFF. A locked sector denies every address inside it and no address outside it.
- R2: When `lock_set` is accepted, the sector that holds `cmd_addr` denies requests from then on. When `lock_clr` is accepted, that sector grants requests again.
- R3: `grant_vld` is high in exactly the cycle after a cycle with `req_vld` high. `grant_ok` in that cycle gives the verdict, where 1 means allowed and 0 means denied.
- R4: While `wp_n` is 0, sectors 0..3 and 138..141 are denied whatever their lock bits hold. Sectors 4..137 are not affected by `wp_n`.
- R5: While `acc_lvl` is 0, every sector is denied.
- R6: After reset, `grant_vld` is 0, every lock bit is clear, the stored key is all ones and the password gate is closed.
- R7: While the password gate is closed, `lock_set` and `lock_clr` have no effect.
- R8: `pw_unlock` opens the gate only when `pw_key` equals the stored key. A key that does not match leaves the gate closed.
- R9: `pw_load` while the gate is open stores `pw_key` as the new key and closes the gate. `pw_load` while the gate is closed is ignored.
- R10: When `lock_set` and `lock_clr` are both high in the same accepted cycle, the set wins.
- R11: A request in the same cycle as a lock command is judged on the lock state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe for a program or erase check |
| req_addr | input | 22 | Word address of the request |
| wp_n | input | 1 | Write-protect pin; 0 guards the outer boot sectors |
| acc_lvl | input | 1 | Acceleration level pin; 0 locks every sector |
| cmd_addr | input | 22 | Address that selects the sector for a lock command |
| lock_set | input | 1 | Set the lock bit of the selected sector |
| lock_clr | input | 1 | Clear the lock bit of the selected sector |
| pw_load | input | 1 | Store `pw_key` as the new key and close the gate |
| pw_unlock | input | 1 | Try to open the gate with `pw_key` |
| pw_key | input | 64 | Key value for load and unlock |
| grant_vld | output | 1 | Verdict valid, one cycle after `req_vld` |
| grant_ok | output | 1 | 1 when allowed, 0 when denied |

## Verification
The bench locks one sector at a time, each of the 142 in turn. After each lock it probes the first word of every sector, plus the last word of the locked one. A map that is shifted or has its region size wrong shows up as a deny in the wrong place or a grant at an edge. Separate sweeps over the first and last word of every sector, first with the write-protect pin low and then with the acceleration pin low, separate the boot-only override from the global one. The password tests send lock commands after a wrong key, a correct key, a reload and a load while closed, and the probes that follow show whether each command changed a lock bit. Same-cycle patterns check that set wins over clear and that a request made alongside a command is judged on the lock state from before it.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

   typedef enum logic [1:0] {
      LK_HOLD = 2'd0,
      LK_SET  = 2'd1,
      LK_CLR  = 2'd2
   } lk_op_e;

   // Number of sectors: every large region except the two end ones,
   // plus the small sectors that the two end regions are split into.
   function automatic int sect_count(input int addr_w, input int big_w, input int small_w);
      return (1 << (addr_w - big_w)) - 2 + 2 * (1 << (big_w - small_w));
   endfunction

endpackage

// File: rtl/wp_sect_map.sv
module wp_sect_map #(
   parameter int ADDR_W   = 22,
   parameter int BIG_W    = 15,
   parameter int SMALL_W  = 12,
   parameter int WP_COUNT = 4,
   parameter int SECT_W   = 8
) (
   input  logic [ADDR_W-SMALL_W-1:0] page,
   output logic [SECT_W-1:0]         idx,
   output logic                      wp_zone
);
   localparam int AREA_W = ADDR_W - BIG_W;
   localparam int SUB_W  = BIG_W - SMALL_W;
   localparam int N_AREA = 1 << AREA_W;
   localparam int BPA    = 1 << SUB_W;
   localparam int N_SECT = N_AREA - 2 + 2 * BPA;

   logic [AREA_W-1:0] area;
   assign area = page[ADDR_W-SMALL_W-1:SUB_W];

   generate
      if (SUB_W == 0) begin : g_uniform
         assign idx = SECT_W'(area);
      end else begin : g_boot_ends
         logic [SUB_W-1:0] sub;
         assign sub = page[SUB_W-1:0];
         always_comb begin
            if (area == '0)
               idx = SECT_W'(sub);
            else if (area == '1)
               idx = SECT_W'(N_AREA - 2 + BPA) + SECT_W'(sub);
            else
               idx = SECT_W'(area) + SECT_W'(BPA - 1);
         end
      end
   endgenerate

   generate
      if (WP_COUNT == 0) begin : g_no_wp
         assign wp_zone = 1'b0;
      end else begin : g_wp
         assign wp_zone = (idx < SECT_W'(WP_COUNT)) ||
                          (idx >= SECT_W'(N_SECT - WP_COUNT));
      end
   endgenerate

endmodule

// File: rtl/wp_lock_bank.sv
module wp_lock_bank
   import wp_guard_pkg::*;
#(
   parameter int N_SECT = 142,
   parameter int SECT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lk_op_e            op,
   input  logic [SECT_W-1:0] op_idx,
   input  logic [SECT_W-1:0] rd_idx,
   output logic              rd_lock,
   output logic [N_SECT-1:0] lock_vec
);
   localparam int N_PAD = 1 << SECT_W;

   logic [N_SECT-1:0] lock_q;
   logic [N_PAD-1:0]  lock_pad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= '0;
      end else begin
         for (int i = 0; i < N_SECT; i++) begin
            if (op_idx == SECT_W'(i)) begin
               if (op == LK_SET)
                  lock_q[i] <= 1'b1;
               else if (op == LK_CLR)
                  lock_q[i] <= 1'b0;
            end
         end
      end
   end

   generate
      if (N_PAD > N_SECT) begin : g_pad
         assign lock_pad = {{(N_PAD - N_SECT){1'b0}}, lock_q};
      end else begin : g_exact
         assign lock_pad = lock_q;
      end
   endgenerate

   assign rd_lock  = lock_pad[rd_idx];
   assign lock_vec = lock_q;

endmodule

// File: rtl/wp_pw_gate.sv
module wp_pw_gate #(
   parameter int              PW_W    = 64,
   parameter logic [PW_W-1:0] PW_INIT = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            unlock,
   input  logic [PW_W-1:0] key,
   output logic            open
);
   logic [PW_W-1:0] key_q;
   logic            open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q  <= PW_INIT;
         open_q <= 1'b0;
      end else if (open_q && load) begin
         key_q  <= key;
         open_q <= 1'b0;
      end else if (!open_q && unlock && (key == key_q)) begin
         open_q <= 1'b1;
      end
   end

   assign open = open_q;

endmodule

// File: rtl/wp_sector_guard.sv
module wp_sector_guard
   import wp_guard_pkg::*;
#(
   parameter int              ADDR_W   = 22,
   parameter int              BIG_W    = 15,
   parameter int              SMALL_W  = 12,
   parameter int              WP_COUNT = 4,
   parameter int              PW_W     = 64,
   parameter logic [PW_W-1:0] PW_INIT  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              wp_n,
   input  logic              acc_lvl,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              lock_set,
   input  logic              lock_clr,
   input  logic              pw_load,
   input  logic              pw_unlock,
   input  logic [PW_W-1:0]   pw_key,
   output logic              grant_vld,
   output logic              grant_ok
);
   localparam int N_SECT = sect_count(ADDR_W, BIG_W, SMALL_W);
   localparam int SECT_W = $clog2(N_SECT);
   localparam int BPA    = 1 << (BIG_W - SMALL_W);
   localparam int PAGE_W = ADDR_W - SMALL_W;

   generate
      if (SMALL_W < 1 || SMALL_W > BIG_W || BIG_W >= ADDR_W - 1) begin : g_bad_geom
         $error("wp_sector_guard: need 1 <= SMALL_W <= BIG_W < ADDR_W-1");
      end
      if (WP_COUNT < 0 || WP_COUNT > BPA) begin : g_bad_wp
         $error("wp_sector_guard: WP_COUNT must lie in 0..boot sectors per end");
      end
      if (PW_W < 1) begin : g_bad_pw
         $error("wp_sector_guard: PW_W must be positive");
      end
   endgenerate

   logic [SECT_W-1:0] req_idx;
   logic [SECT_W-1:0] cmd_idx;
   logic              req_wp_zone;
   logic              cmd_wp_zone_unused;
   logic              unused_low_bits;
   logic              pw_open;
   logic              rd_lock;
   logic [N_SECT-1:0] lock_vec;
   lk_op_e            lk_op;
   logic              deny;

   assign unused_low_bits = ^{req_addr[SMALL_W-1:0], cmd_addr[SMALL_W-1:0], cmd_wp_zone_unused};

   wp_sect_map #(
      .ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
      .WP_COUNT(WP_COUNT), .SECT_W(SECT_W)
   ) u_req_map (
      .page    (req_addr[ADDR_W-1:SMALL_W]),
      .idx     (req_idx),
      .wp_zone (req_wp_zone)
   );

   wp_sect_map #(
      .ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
      .WP_COUNT(WP_COUNT), .SECT_W(SECT_W)
   ) u_cmd_map (
      .page    (cmd_addr[ADDR_W-1:ADDR_W-PAGE_W]),
      .idx     (cmd_idx),
      .wp_zone (cmd_wp_zone_unused)
   );

   wp_pw_gate #(
      .PW_W(PW_W), .PW_INIT(PW_INIT)
   ) u_pw (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (pw_load),
      .unlock (pw_unlock),
      .key    (pw_key),
      .open   (pw_open)
   );

   always_comb begin
      lk_op = LK_HOLD;
      if (pw_open) begin
         if (lock_set)
            lk_op = LK_SET;
         else if (lock_clr)
            lk_op = LK_CLR;
      end
   end

   wp_lock_bank #(
      .N_SECT(N_SECT), .SECT_W(SECT_W)
   ) u_locks (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (lk_op),
      .op_idx   (cmd_idx),
      .rd_idx   (req_idx),
      .rd_lock  (rd_lock),
      .lock_vec (lock_vec)
   );

   assign deny = rd_lock || (!wp_n && req_wp_zone) || !acc_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_vld <= 1'b0;
         grant_ok  <= 1'b0;
      end else begin
         grant_vld <= req_vld;
         grant_ok  <= req_vld && !deny;
      end
   end

endmodule

// File: rtl/wp_sector_guard_chk.sv
module wp_sector_guard_chk #(
   parameter int ADDR_W   = 22,
   parameter int BIG_W    = 15,
   parameter int SMALL_W  = 12,
   parameter int WP_COUNT = 4,
   parameter int N_SECT   = 142
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic [ADDR_W-1:0] req_addr,
   input logic              wp_n,
   input logic              acc_lvl,
   input logic              pw_load,
   input logic              pw_unlock,
   input logic              grant_vld,
   input logic              grant_ok,
   input logic              pw_open,
   input logic [N_SECT-1:0] lock_vec
);
   localparam int AREA_W = ADDR_W - BIG_W;
   localparam int BPA    = 1 << (BIG_W - SMALL_W);

   logic [AREA_W-1:0] c_area;
   int                c_sub;
   logic              c_edge;

   assign c_area = req_addr[ADDR_W-1:BIG_W];

   always_comb begin
      c_sub  = int'(req_addr[BIG_W-1:0] >> SMALL_W);
      c_edge = ((c_area == '0) && (c_sub < WP_COUNT)) ||
               ((c_area == '1) && (c_sub >= BPA - WP_COUNT));
   end

   p_grant_tracks_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> grant_vld);

   p_grant_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !grant_vld);

   p_acc_low_denies_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !acc_lvl) |=> !grant_ok);

   p_wp_edge_denies_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !wp_n && c_edge) |=> !grant_ok);

   p_closed_freezes_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pw_open |=> $stable(lock_vec));

   p_only_unlock_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pw_open && !pw_unlock) |=> !pw_open);

   p_load_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_open && pw_load) |=> !pw_open);

endmodule

bind wp_sector_guard wp_sector_guard_chk #(
   .ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
   .WP_COUNT(WP_COUNT), .N_SECT(N_SECT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_addr  (req_addr),
   .wp_n      (wp_n),
   .acc_lvl   (acc_lvl),
   .pw_load   (pw_load),
   .pw_unlock (pw_unlock),
   .grant_vld (grant_vld),
   .grant_ok  (grant_ok),
   .pw_open   (pw_open),
   .lock_vec  (lock_vec)
);

// File: tb/wp_sector_guard_bench.sv
module wp_sector_guard_bench;
   localparam int ADDR_W = 22;
   localparam int PW_W   = 64;
   localparam int NS     = 142;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_vld = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              wp_n = 1'b1;
   logic              acc_lvl = 1'b1;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic              lock_set = 1'b0;
   logic              lock_clr = 1'b0;
   logic              pw_load = 1'b0;
   logic              pw_unlock = 1'b0;
   logic [PW_W-1:0]   pw_key = '0;
   logic              grant_vld;
   logic              grant_ok;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 0;

   always #4 clk = ~clk;

   wp_sector_guard u_wp_sector_guard (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
      .wp_n(wp_n), .acc_lvl(acc_lvl), .cmd_addr(cmd_addr),
      .lock_set(lock_set), .lock_clr(lock_clr), .pw_load(pw_load),
      .pw_unlock(pw_unlock), .pw_key(pw_key),
      .grant_vld(grant_vld), .grant_ok(grant_ok)
   );

   function automatic int sbase(input int s);
      if (s < 8)   return s * 4096;
      if (s < 134) return (s - 7) * 32768;
      return 127 * 32768 + (s - 134) * 4096;
   endfunction

   function automatic int slast(input int s);
      if (s < 8 || s >= 134) return sbase(s) + 4095;
      return sbase(s) + 32767;
   endfunction

   task automatic check(input string rq, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic probe(input string rq, input int addr, input bit exp_ok);
      @(negedge clk);
      req_vld  = 1'b1;
      req_addr = ADDR_W'(addr);
      @(negedge clk);
      req_vld  = 1'b0;
      if (grant_vld !== 1'b1) check({rq, " vld"}, int'(grant_vld), 1);
      check(rq, int'(grant_ok), int'(exp_ok));
   endtask

   task automatic lock_cmd(input bit s, input bit c, input int addr);
      @(negedge clk);
      lock_set = s;
      lock_clr = c;
      cmd_addr = ADDR_W'(addr);
      @(negedge clk);
      lock_set = 1'b0;
      lock_clr = 1'b0;
   endtask

   task automatic pw_cmd(input bit ld, input bit ul, input logic [PW_W-1:0] k);
      @(negedge clk);
      pw_load   = ld;
      pw_unlock = ul;
      pw_key    = k;
      @(negedge clk);
      pw_load   = 1'b0;
      pw_unlock = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run finished)");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R6 vld in reset", int'(grant_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 vld after reset", int'(grant_vld), 0);

      // R6: every sector open after reset
      for (int s = 0; s < NS; s++) probe("R6", sbase(s), 1'b1);

      // R7: closed gate ignores set
      lock_cmd(1'b1, 1'b0, sbase(10));
      probe("R7", sbase(10), 1'b1);

      // R8: wrong key keeps gate closed
      pw_cmd(1'b0, 1'b1, 64'h0123_4567_89AB_CDEF);
      lock_cmd(1'b1, 1'b0, sbase(10));
      probe("R8 mismatch", sbase(10), 1'b1);
      // R8 and R6: the reset key is all ones
      pw_cmd(1'b0, 1'b1, '1);
      lock_cmd(1'b1, 1'b0, sbase(10));
      probe("R8 match", sbase(10), 1'b0);
      lock_cmd(1'b0, 1'b1, sbase(10));
      probe("R2 clear", sbase(10), 1'b1);

      // R1, R2: one sector locked at a time, probe every sector
      for (int s = 0; s < NS; s++) begin
         lock_cmd(1'b1, 1'b0, slast(s));
         for (int t = 0; t < NS; t++) probe(t == s ? "R2" : "R1", sbase(t), t != s);
         probe("R1 last word", slast(s), 1'b0);
         lock_cmd(1'b0, 1'b1, sbase(s));
         probe("R2 cleared", slast(s), 1'b1);
      end

      // R4: write-protect pin guards only the outer four per end
      wp_n = 1'b0;
      for (int s = 0; s < NS; s++) begin
         probe("R4", sbase(s), !(s < 4 || s >= 138));
         probe("R4", slast(s), !(s < 4 || s >= 138));
      end
      wp_n = 1'b1;
      probe("R4 released", sbase(0), 1'b1);

      // R5: acceleration pin low locks all
      acc_lvl = 1'b0;
      for (int s = 0; s < NS; s++) probe("R5", sbase(s), 1'b0);
      acc_lvl = 1'b1;
      probe("R5 released", sbase(70), 1'b1);

      // R10: set wins over clear
      lock_cmd(1'b1, 1'b1, sbase(20));
      probe("R10", sbase(20), 1'b0);
      lock_cmd(1'b0, 1'b1, sbase(20));

      // R11: request alongside a set sees old state
      @(negedge clk);
      lock_set = 1'b1; cmd_addr = ADDR_W'(sbase(30));
      req_vld  = 1'b1; req_addr = ADDR_W'(sbase(30));
      @(negedge clk);
      lock_set = 1'b0; req_vld = 1'b0;
      check("R11 old state", int'(grant_ok), 1);
      // R3: valid only one cycle
      @(negedge clk);
      check("R3 vld drop", int'(grant_vld), 0);
      probe("R11 new state", sbase(30), 1'b0);
      lock_cmd(1'b0, 1'b1, sbase(30));

      // R9: load closes gate with new key
      pw_cmd(1'b1, 1'b0, 64'hA5A5_0000_1234_5678);
      lock_cmd(1'b1, 1'b0, sbase(40));
      probe("R9 closed after load", sbase(40), 1'b1);
      pw_cmd(1'b0, 1'b1, '1);
      lock_cmd(1'b1, 1'b0, sbase(40));
      probe("R9 old key rejected", sbase(40), 1'b1);
      pw_cmd(1'b0, 1'b1, 64'hA5A5_0000_1234_5678);
      lock_cmd(1'b1, 1'b0, sbase(40));
      probe("R9 new key opens", sbase(40), 1'b0);
      pw_cmd(1'b1, 1'b0, 64'h0000_0000_0000_0042);
      pw_cmd(1'b1, 1'b0, 64'h0000_0000_0000_0099);
      pw_cmd(1'b0, 1'b1, 64'h0000_0000_0000_0099);
      lock_cmd(1'b0, 1'b1, sbase(40));
      probe("R9 load while closed ignored", sbase(40), 1'b0);
      pw_cmd(1'b0, 1'b1, 64'h0000_0000_0000_0042);
      lock_cmd(1'b0, 1'b1, sbase(40));
      probe("R9 kept key opens", sbase(40), 1'b1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule